// File: doc/BRIEF.md
# Bulk Command Register-Write Decoder

This block takes a byte stream of bulk display commands over a valid/ready input. It picks out the register-write commands and applies them to a bank of 8-bit display registers. A command opens with the prefix byte 0xAF and continues with a one-byte command code. A register write is four bytes long: the prefix, the code 0x20, a register index and a value. Any other command code is treated as unknown. The decoder then discards bytes until it sees the next prefix byte, so pixel-copy and compression traffic passes through without effect.

The registers are held twice, as a staging (shadow) bank and a live (active) bank. Writing 0x00 to index 0xFF locks the live bank. After that, register writes land only in the staging bank. Writing 0xFF to index 0xFF unlocks the bank and copies the whole staging bank into the live bank on one clock edge. A mode change therefore appears on the live registers all at once.

Every decoded write is echoed on a one-cycle write port. A 16-bit read-back port returns a pair of adjacent live registers. For most pairs the lower index holds the high byte. The pixel-clock pair is stored the other way round, and the read-back port reverses its bytes to match.

Top module: `bulk_regwr_decoder`

## Requirements
- R1: With the parser waiting for a command start, any byte other than 0xAF is dropped, with no write and no change of parse position.
- R2: The byte sequence 0xAF, 0x20, idx, val causes exactly one write-port pulse carrying idx and val. The pulse is visible in the cycle after the edge that accepts the value byte.
- R3: After 0xAF followed by a command code other than 0x20 or 0xAF, every byte is discarded up to the next 0xAF, even bytes equal to 0x20. Parsing then resumes with that 0xAF as the prefix.
- R4: A 0xAF received where a command code is expected counts as a fresh prefix. A lone 0xAF used as padding therefore has no effect, and the command after it decodes normally.
- R5: While unlocked, a write to an index below NUM_REGS updates both banks on the value-byte edge. The new value shows on read-back right after that edge.
- R6: Writing 0x00 to index 0xFF locks the bank. While locked, register writes change only the staging bank, and the live bank read back stays unchanged.
- R7: Writing 0xFF to index 0xFF unlocks the bank and copies every staging register into the live bank on that same edge.
- R8: For any read index i other than the pixel-clock base, the read-back word is {reg[i], reg[i+1]}, with i+1 wrapping to 0 after NUM_REGS-1.
- R9: For read index PIXCLK_IDX (default 0x1B), the read-back word is {reg[0x1C], reg[0x1B]}, so the low byte sits at the lower index.
- R10: A write to an index from NUM_REGS up to 0xFE, or a value to 0xFF other than 0x00 or 0xFF, changes neither bank nor the lock state. It is still echoed on the write port.
- R11: During reset in_ready and wr_valid are low. After reset all registers read back zero, the bank is unlocked and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Command stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| wr_valid | output | 1 | One-cycle pulse for a decoded register write |
| wr_index | output | 8 | Register index of the decoded write |
| wr_value | output | 8 | Value of the decoded write |
| rd_index | input | IDX_W | Base index of the register pair to read |
| rd_word | output | 16 | Live register pair, byte-ordered per pair |

## Verification
A commit of the staging bank and a read-back of that bank's contents fall in the same cycle. The bench holds rd_index on the pixel-clock pair and the base-address registers, which were written only while locked. It then sends the unlock command and samples read-back immediately after the edge that takes the unlock value. The staged values must show in that sample, in their pair-specific byte order. A second overlap pairs a command-code slot with a stray prefix: padding 0xAF bytes arrive directly before a real write, and the scoreboard must see exactly that one write.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam logic [7:0] PREFIX_BYTE   = 8'hAF;
    localparam logic [7:0] CMD_REG_WRITE = 8'h20;
    localparam logic [7:0] LOCK_INDEX    = 8'hFF;
    localparam logic [7:0] LOCK_VALUE    = 8'h00;
    localparam logic [7:0] UNLOCK_VALUE  = 8'hFF;

    typedef enum logic [2:0] {
        ST_PREFIX,
        ST_CODE,
        ST_INDEX,
        ST_VALUE,
        ST_SKIP
    } parse_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] idx;
        logic [7:0] data;
    } reg_write_t;

    // Compose a 16-bit word from the bytes at the lower and upper index.
    function automatic logic [15:0] join_pair(input logic [7:0] at_low,
                                              input logic [7:0] at_high,
                                              input logic       swapped);
        return swapped ? {at_high, at_low} : {at_low, at_high};
    endfunction

endpackage

// File: rtl/bcd_cmd_parser.sv
module bcd_cmd_parser
    import bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output reg_write_t wr_now,
    output reg_write_t wr_q
);

    parse_state_e state_q, state_d;
    logic [7:0]   idx_q;
    logic         ready_q;
    logic         fire;

    assign in_ready = ready_q;
    assign fire     = in_valid && ready_q;

    always_comb begin
        state_d = state_q;
        if (fire) begin
            case (state_q)
                ST_PREFIX: if (in_data == PREFIX_BYTE) state_d = ST_CODE;
                ST_CODE: begin
                    if (in_data == CMD_REG_WRITE)    state_d = ST_INDEX;
                    else if (in_data == PREFIX_BYTE) state_d = ST_CODE;
                    else                             state_d = ST_SKIP;
                end
                ST_INDEX: state_d = ST_VALUE;
                ST_VALUE: state_d = ST_PREFIX;
                ST_SKIP:  if (in_data == PREFIX_BYTE) state_d = ST_CODE;
                default:  state_d = ST_PREFIX;
            endcase
        end
    end

    always_comb begin
        wr_now.valid = fire && (state_q == ST_VALUE);
        wr_now.idx   = idx_q;
        wr_now.data  = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PREFIX;
            idx_q   <= '0;
            ready_q <= 1'b0;
            wr_q    <= '0;
        end else begin
            state_q <= state_d;
            ready_q <= 1'b1;
            wr_q    <= wr_now;
            if (fire && state_q == ST_INDEX) idx_q <= in_data;
        end
    end

    // R1
    prefix_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PREFIX && fire && in_data != PREFIX_BYTE) |=> (state_q == ST_PREFIX));

    // R3
    skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SKIP && fire && in_data != PREFIX_BYTE) |=> (state_q == ST_SKIP));

    // R4
    reprefix_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && in_data == PREFIX_BYTE &&
         (state_q == ST_PREFIX || state_q == ST_CODE || state_q == ST_SKIP))
        |=> (state_q == ST_CODE));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_q.valid |=> !wr_q.valid);

endmodule

// File: rtl/bcd_reg_banks.sv
module bcd_reg_banks
    import bcd_pkg::*;
#(
    parameter int NUM_REGS = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  reg_write_t                     wr,
    output logic [NUM_REGS-1:0][7:0]       active_o,
    output logic                           locked_o
);

    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    logic [NUM_REGS-1:0][7:0] shadow_q;
    logic [NUM_REGS-1:0][7:0] active_q;
    logic                     locked_q;
    logic                     in_range;
    logic                     lock_hit;
    logic                     commit;
    logic                     do_lock;
    logic [IDX_W-1:0]         wr_idx_lo;

    assign in_range  = wr.valid && ({1'b0, wr.idx} < LIMIT);
    assign lock_hit  = wr.valid && (wr.idx == LOCK_INDEX);
    assign commit    = lock_hit && (wr.data == UNLOCK_VALUE);
    assign do_lock   = lock_hit && (wr.data == LOCK_VALUE);
    assign wr_idx_lo = wr.idx[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)          locked_q <= 1'b0;
        else if (commit)  locked_q <= 1'b0;
        else if (do_lock) locked_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = in_range && (wr_idx_lo == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst)      shadow_q[g] <= '0;
            else if (hit) shadow_q[g] <= wr.data;
        end

        always_ff @(posedge clk) begin
            if (rst)                    active_q[g] <= '0;
            else if (commit)            active_q[g] <= shadow_q[g];
            else if (hit && !locked_q)  active_q[g] <= wr.data;
        end
    end

    assign active_o = active_q;
    assign locked_o = locked_q;

    // R5
    live_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_range && !locked_q) |=> (active_q[$past(wr_idx_lo)] == $past(wr.data)));

    // R6
    locked_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !commit) |=> $stable(active_q));

    // R7
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == $past(shadow_q) && !locked_q));

    // R10
    lock_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_hit && !commit && !do_lock) |=> (locked_q == $past(locked_q)));

endmodule

// File: rtl/bcd_readback.sv
module bcd_readback
    import bcd_pkg::*;
#(
    parameter int NUM_REGS   = 64,
    parameter int PIXCLK_IDX = 8'h1B,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][7:0] active,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [15:0]              rd_word
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] SWAP_IDX = IDX_W'(PIXCLK_IDX);

    logic [IDX_W-1:0] nxt_idx;
    logic             swapped;

    assign nxt_idx = (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
    assign swapped = (rd_idx == SWAP_IDX);
    assign rd_word = join_pair(active[rd_idx], active[nxt_idx], swapped);

endmodule

// File: rtl/bulk_regwr_decoder.sv
module bulk_regwr_decoder
    import bcd_pkg::*;
#(
    parameter int NUM_REGS   = 64,
    parameter int PIXCLK_IDX = 8'h1B,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             wr_valid,
    output logic [7:0]       wr_index,
    output logic [7:0]       wr_value,
    input  logic [IDX_W-1:0] rd_index,
    output logic [15:0]      rd_word
);

    reg_write_t               wr_now;
    reg_write_t               wr_q;
    logic [NUM_REGS-1:0][7:0] active;
    logic                     locked;

    bcd_cmd_parser u_parser (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .wr_now   (wr_now),
        .wr_q     (wr_q)
    );

    bcd_reg_banks #(.NUM_REGS(NUM_REGS)) u_banks (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_now),
        .active_o (active),
        .locked_o (locked)
    );

    bcd_readback #(.NUM_REGS(NUM_REGS), .PIXCLK_IDX(PIXCLK_IDX)) u_rd (
        .active  (active),
        .rd_idx  (rd_index),
        .rd_word (rd_word)
    );

    assign wr_valid = wr_q.valid;
    assign wr_index = wr_q.idx;
    assign wr_value = wr_q.data;

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!wr_valid && !in_ready && !locked));

endmodule

// File: tb/tb_bulk_regwr_decoder.sv
module tb_bulk_regwr_decoder;

    localparam int NREG  = 64;
    localparam int IW    = 6;
    localparam int PIXCK = 8'h1B;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          wr_valid;
    logic [7:0]    wr_index;
    logic [7:0]    wr_value;
    logic [IW-1:0] rd_index = '0;
    logic [15:0]   rd_word;

    int total = 0;
    int bad   = 0;

    logic [15:0] exp_q[$];
    logic [7:0]  m_act [NREG];
    logic [7:0]  m_sh  [NREG];
    logic        m_locked = 1'b0;

    always #2.5 clk = ~clk;

    bulk_regwr_decoder #(.NUM_REGS(NREG), .PIXCLK_IDX(PIXCK)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_value(wr_value), .rd_index(rd_index), .rd_word(rd_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every write-port pulse (R2)
    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected write", {16'h0, wr_index, wr_value}, 32'hFFFF_FFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check("R2 write port", {16'h0, wr_index, wr_value}, {16'h0, e});
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_write(input logic [7:0] idx, input logic [7:0] val);
        exp_q.push_back({idx, val});
        if (idx < NREG) begin
            m_sh[idx] = val;
            if (!m_locked) m_act[idx] = val;
        end else if (idx == 8'hFF && val == 8'h00) begin
            m_locked = 1'b1;
        end else if (idx == 8'hFF && val == 8'hFF) begin
            m_locked = 1'b0;
            for (int k = 0; k < NREG; k++) m_act[k] = m_sh[k];
        end
        send_byte(8'hAF);
        send_byte(8'h20);
        send_byte(idx);
        send_byte(val);
    endtask

    task automatic check_rd(input string req, input int idx);
        logic [15:0] e;
        int nx;
        nx = (idx == NREG - 1) ? 0 : idx + 1;
        e = (idx == PIXCK) ? {m_act[nx], m_act[idx]} : {m_act[idx], m_act[nx]};
        rd_index = IW'(idx);
        #1;
        check(req, {16'h0, rd_word}, {16'h0, e});
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) begin
            m_act[k] = '0;
            m_sh[k]  = '0;
        end
        repeat (3) @(negedge clk);
        // R11 during reset
        check("R11 ready in reset", {31'h0, in_ready}, 32'h0);
        check("R11 wr_valid in reset", {31'h0, wr_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 ready after reset", {31'h0, in_ready}, 32'h1);
        check_rd("R11 zero regs", 8'h00);
        check_rd("R11 zero pixclk", PIXCK);

        // R2 R5 R8: live writes and normal pair order
        send_write(8'h10, 8'h12);
        send_write(8'h11, 8'h34);
        check_rd("R5 R8 pair 0x10", 8'h10);
        check("R8 literal", {16'h0, rd_word}, 32'h0000_1234);

        // R1: stray bytes before a prefix
        send_byte(8'h00);
        send_byte(8'h20);
        send_byte(8'h05);
        send_byte(8'h07);
        check_rd("R1 stray bytes no effect", 8'h05);
        send_write(8'h12, 8'h56);
        check_rd("R1 write after strays", 8'h11);

        // R3: unknown command, 0x20 inside skipped bytes must not revive
        send_byte(8'hAF);
        send_byte(8'h38);
        send_byte(8'h20);
        send_byte(8'h05);
        send_byte(8'h07);
        check_rd("R3 skipped bytes", 8'h05);
        send_write(8'h30, 8'h99);
        check_rd("R3 resync", 8'h30);

        // R4: lone and double padding prefixes
        send_byte(8'hAF);
        send_write(8'h08, 8'h77);
        send_byte(8'hAF);
        send_byte(8'hAF);
        send_write(8'h09, 8'h66);
        check_rd("R4 padding", 8'h08);

        // R6: lock, stage base address and pixel clock
        send_write(8'hFF, 8'h00);
        send_write(8'h1B, 8'h50);
        send_write(8'h1C, 8'h01);
        send_write(8'h20, 8'hAB);
        send_write(8'h21, 8'hCD);
        send_write(8'h22, 8'hEF);
        send_write(8'h10, 8'hEE);
        check_rd("R6 frozen pixclk", PIXCK);
        check_rd("R6 frozen base", 8'h20);
        check_rd("R6 frozen old reg", 8'h10);

        // R7 R9: unlock commits; read back right after the unlock edge
        rd_index = IW'(PIXCK);
        send_write(8'hFF, 8'hFF);
        check("R7 R9 commit same edge", {16'h0, rd_word}, 32'h0000_0150);
        check_rd("R7 base hi", 8'h20);
        check_rd("R7 base lo", 8'h21);
        check_rd("R7 overwritten reg", 8'h10);

        // R10: out-of-range index and odd lock values
        send_write(8'h40, 8'h3C);
        send_write(8'hFE, 8'h3D);
        check_rd("R10 no alias", 8'h00);
        send_write(8'hFF, 8'h55);
        send_write(8'h02, 8'h11);
        check_rd("R10 still unlocked", 8'h02);

        // R8 wrap of the upper index
        send_write(8'h3F, 8'h42);
        check_rd("R8 wrap", 8'h3F);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule